// File: doc/BRIEF.md
# Banked Register File Decoder

This block is the data-memory front end of a small 8-bit controller. Each access names a byte either through a 7-bit offset taken from the instruction, combined with a bank-select bit, or through a full 8-bit pointer value. The block resolves that address into one of four kinds of space and then carries out the byte read or write.

Low offsets in either bank belong to special-function registers. These are not stored here. Their accesses leave the block on a strobe that carries the bank and offset, with a separate data path in each direction. The remaining space is general-purpose RAM held in an internal array. The top sixteen bytes of the second bank are a second view of the top sixteen RAM bytes of the first bank. Every other location is absent: it reads as zero and ignores writes. The bank-select bit and the two reserved status bits arrive as inputs. The reserved bits play no part in decoding.

Top module: `banked_regfile`

## Requirements
- R1: The effective address is `{bank_sel, dir_ofs}` when `use_ptr` is 0. When `use_ptr` is 1 it is `ptr_addr`, and `bank_sel` is ignored. Bit 7 of the effective address is the bank (0 = first bank, 1 = second bank) and bits 6:0 are the offset.
- R2: When the offset is below 20h, in either bank, `sfr_req` is 1. In that case `sfr_bank` is bit 7 of the address, `sfr_ofs` is bits 4:0, `rd_data` equals `sfr_rdata`, and the internal RAM is not written.
- R3: First-bank addresses 20h–7Fh each hold an independent byte. The byte written to an address is read back from that address later.
- R4: Second-bank addresses A0h–BFh hold 32 bytes that are separate from every first-bank byte.
- R5: Second-bank addresses F0h–FFh read and write the same bytes as first-bank addresses 70h–7Fh, in both directions.
- R6: Second-bank addresses C0h–EFh read as 00h. Writes to them change no stored byte and raise no strobe.
- R7: The reserved status bits `status_rsv` have no effect on decoding, on read data or on writes.
- R8: A write takes effect at the rising clock edge while `wr_en` is 1. `rd_data` follows the address without a clock, so during the write cycle it shows the old byte and after the edge it shows the new one.
- R9: `sfr_we` is 1 only when `wr_en` is 1 and `sfr_req` is 1. When `sfr_we` is 1, `sfr_wdata` equals `wr_data`. `sfr_req` is 0 for any address at offset 20h or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| use_ptr | input | 1 | 1 selects pointer addressing |
| dir_ofs | input | 7 | Offset taken from the instruction |
| ptr_addr | input | 8 | Full pointer address |
| bank_sel | input | 1 | Bank-select status bit |
| status_rsv | input | 2 | Reserved status bits, ignored |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte |
| sfr_req | output | 1 | Special-function access strobe |
| sfr_we | output | 1 | Special-function write strobe |
| sfr_bank | output | 1 | Bank of the special-function access |
| sfr_ofs | output | 5 | Offset of the special-function access |
| sfr_wdata | output | 8 | Byte sent on a special-function write |
| sfr_rdata | input | 8 | Byte returned by special-function logic |

## Verification
The first-bank RAM is filled with bytes derived from their addresses and then with walking-one bytes. This shows that no two offsets share storage and that every data bit is stored. A byte is written at one end of the shared window and read back at the other end, then the same is done the other way round. Comparing those results against the A0h–BFh bytes tells a true alias apart from a wrong index offset. Pointer accesses are made with a contrary `bank_sel`, and the decode is repeated with every reserved-bit pattern, to show that neither changes the result. A write whose data changes in the same cycle separates a read path without a clock from one with a register in it.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DATA_W   = 8;
  localparam int OFS_W    = 7;
  localparam int ADDR_W   = OFS_W + 1;
  localparam int SFR_SPAN = 32;
  localparam int B1_GPR_N = 32;
  localparam int ALIAS_N  = 16;

  localparam int B0_GPR_N  = (1 << OFS_W) - SFR_SPAN;
  localparam int RAM_DEPTH = B0_GPR_N + B1_GPR_N;
  localparam int IDX_W     = $clog2(RAM_DEPTH);

  localparam logic [OFS_W-1:0] SFR_END   = OFS_W'(SFR_SPAN);
  localparam logic [OFS_W-1:0] B1_END    = OFS_W'(SFR_SPAN + B1_GPR_N);
  localparam logic [OFS_W-1:0] ALIAS_LO  = OFS_W'((1 << OFS_W) - ALIAS_N);

  typedef enum logic [1:0] {
    RG_SFR    = 2'd0,
    RG_GPR    = 2'd1,
    RG_MIRROR = 2'd2,
    RG_NONE   = 2'd3
  } region_e;

  typedef struct packed {
    region_e            region;
    logic [IDX_W-1:0]   idx;
  } decode_t;

  function automatic logic [ADDR_W-1:0] form_addr(
    input logic              ptr_mode,
    input logic              bank,
    input logic [OFS_W-1:0]  ofs,
    input logic [ADDR_W-1:0] ptr
  );
    return ptr_mode ? ptr : {bank, ofs};
  endfunction

  function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
    decode_t            d;
    logic               bank;
    logic [OFS_W-1:0]   ofs;
    logic [OFS_W-1:0]   rel;
    bank     = a[ADDR_W-1];
    ofs      = a[OFS_W-1:0];
    rel      = ofs - SFR_END;
    d.region = RG_NONE;
    d.idx    = '0;
    if (ofs < SFR_END) begin
      d.region = RG_SFR;
    end else if (!bank) begin
      d.region = RG_GPR;
      d.idx    = IDX_W'(rel);
    end else if (ofs < B1_END) begin
      d.region = RG_GPR;
      d.idx    = IDX_W'(B0_GPR_N) + IDX_W'(rel);
    end else if (ofs >= ALIAS_LO) begin
      d.region = RG_MIRROR;
      d.idx    = IDX_W'(rel);
    end
    return d;
  endfunction
endpackage

// File: rtl/rf_addr_sel.sv
module rf_addr_sel
  import rf_pkg::*;
(
  input  logic              use_ptr,
  input  logic              bank_sel,
  input  logic [OFS_W-1:0]  dir_ofs,
  input  logic [ADDR_W-1:0] ptr_addr,
  output logic [ADDR_W-1:0] eff_addr
);
  always_comb begin
    eff_addr = form_addr(use_ptr, bank_sel, dir_ofs, ptr_addr);
  end
endmodule

// File: rtl/rf_region_dec.sv
module rf_region_dec
  import rf_pkg::*;
(
  input  logic [ADDR_W-1:0] eff_addr,
  output region_e           region,
  output logic [IDX_W-1:0]  ram_idx,
  output logic              sfr_hit,
  output logic              ram_hit
);
  decode_t dec;

  always_comb begin
    dec     = decode_addr(eff_addr);
    region  = dec.region;
    ram_idx = dec.idx;
    sfr_hit = (dec.region == RG_SFR);
    ram_hit = (dec.region == RG_GPR) || (dec.region == RG_MIRROR);
  end
endmodule

// File: rtl/rf_gpr_ram.sv
module rf_gpr_ram
  import rf_pkg::*;
#(
  parameter int DEPTH = RAM_DEPTH,
  parameter int AW    = IDX_W,
  parameter int DW    = DATA_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_comb begin
    rdata = mem[idx];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_ptr,
  input  logic [OFS_W-1:0]  dir_ofs,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic              bank_sel,
  input  logic [1:0]        status_rsv,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              sfr_req,
  output logic              sfr_we,
  output logic              sfr_bank,
  output logic [4:0]        sfr_ofs,
  output logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] sfr_rdata
);
  logic [ADDR_W-1:0] eff_addr;
  region_e           region;
  logic [IDX_W-1:0]  ram_idx;
  logic              sfr_hit;
  logic              ram_hit;
  logic              ram_we;
  logic [DATA_W-1:0] ram_rdata;
  logic              rsv_seen;
  logic              run_ok;

  // Reserved bits are observed only by the checker; decode ignores them.
  assign rsv_seen = |status_rsv;
  assign run_ok   = rst_n;

  rf_addr_sel u_sel (
    .use_ptr  (use_ptr),
    .bank_sel (bank_sel),
    .dir_ofs  (dir_ofs),
    .ptr_addr (ptr_addr),
    .eff_addr (eff_addr)
  );

  rf_region_dec u_dec (
    .eff_addr (eff_addr),
    .region   (region),
    .ram_idx  (ram_idx),
    .sfr_hit  (sfr_hit),
    .ram_hit  (ram_hit)
  );

  assign ram_we = wr_en && ram_hit && run_ok;

  rf_gpr_ram u_ram (
    .clk   (clk),
    .we    (ram_we),
    .idx   (ram_idx),
    .wdata (wr_data),
    .rdata (ram_rdata)
  );

  always_comb begin
    unique case (region)
      RG_SFR:            rd_data = sfr_rdata;
      RG_GPR, RG_MIRROR: rd_data = ram_rdata;
      default:           rd_data = '0;
    endcase
  end

  always_comb begin
    sfr_req   = sfr_hit;
    sfr_we    = sfr_hit && wr_en;
    sfr_bank  = sfr_hit ? eff_addr[ADDR_W-1] : 1'b0;
    sfr_ofs   = sfr_hit ? eff_addr[4:0] : 5'd0;
    sfr_wdata = (sfr_hit && wr_en) ? wr_data : '0;
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import rf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              use_ptr,
  input logic [ADDR_W-1:0] ptr_addr,
  input logic              bank_sel,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              sfr_req,
  input logic              sfr_we,
  input logic              sfr_bank,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              ram_hit,
  input logic              rsv_seen
);
  logic in_hole;
  assign in_hole = eff_addr[ADDR_W-1] && (eff_addr[OFS_W-1:0] >= B1_END)
                   && (eff_addr[OFS_W-1:0] < ALIAS_LO);

  assert_sfr_we_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_we |-> (sfr_req && wr_en && sfr_wdata == wr_data));

  assert_sfr_bank_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_req |-> (sfr_bank == (use_ptr ? ptr_addr[ADDR_W-1] : bank_sel)));

  assert_sfr_low_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_req |-> (eff_addr[OFS_W-1:0] < SFR_END) && !ram_hit);

  assert_hole_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_hole |-> (rd_data == '0 && !sfr_req && !ram_hit));

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_hit && wr_en) |=> (!$stable(eff_addr) || rd_data == $past(wr_data)));

  assert_rsv_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_seen && ram_hit) |-> !sfr_req);
endmodule

bind banked_regfile banked_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .use_ptr   (use_ptr),
  .ptr_addr  (ptr_addr),
  .bank_sel  (bank_sel),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .sfr_req   (sfr_req),
  .sfr_we    (sfr_we),
  .sfr_bank  (sfr_bank),
  .sfr_wdata (sfr_wdata),
  .eff_addr  (eff_addr),
  .ram_hit   (ram_hit),
  .rsv_seen  (rsv_seen)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       use_ptr = 1'b0;
  logic [6:0] dir_ofs = '0;
  logic [7:0] ptr_addr = '0;
  logic       bank_sel = 1'b0;
  logic [1:0] status_rsv = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sfr_req;
  logic       sfr_we;
  logic       sfr_bank;
  logic [4:0] sfr_ofs;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata = 8'h5A;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [256];

  banked_regfile dut (
    .clk(clk), .rst_n(rst_n), .use_ptr(use_ptr), .dir_ofs(dir_ofs),
    .ptr_addr(ptr_addr), .bank_sel(bank_sel), .status_rsv(status_rsv),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sfr_req(sfr_req),
    .sfr_we(sfr_we), .sfr_bank(sfr_bank), .sfr_ofs(sfr_ofs),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Storage home of an address: -1 none, -2 special, else model slot
  function automatic int home(input logic [7:0] a);
    if (a[6:0] < 7'h20) return -2;
    if (a < 8'h80) return int'(a);
    if (a >= 8'hA0 && a <= 8'hBF) return int'(a);
    if (a >= 8'hF0) return int'(a) - 128;
    return -1;
  endfunction

  function automatic logic [7:0] expect_rd(input logic [7:0] a);
    int h;
    h = home(a);
    if (h == -2) return sfr_rdata;
    if (h == -1) return 8'h00;
    return model[h];
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic put_addr(input logic [7:0] a);
    use_ptr  = 1'b0;
    bank_sel = a[7];
    dir_ofs  = a[6:0];
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    put_addr(a);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (home(a) >= 0) model[home(a)] = d;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    @(negedge clk);
    put_addr(a);
    wr_en = 1'b0;
    #1;
    chk(req, rd_data, expect_rd(a));
  endtask

  task automatic t_reset;
    #1;
    chk("R9 reset sfr_we", sfr_we, 0);
    put_addr(8'hC4);
    #1;
    chk("R6 reset hole read", rd_data, 0);
    chk("R9 reset no strobe", sfr_req, 0);
  endtask

  task automatic t_bank0_fill;
    for (int a = 8'h20; a < 8'h80; a++) wr(8'(a), 8'(a ^ 8'hC3));
    for (int a = 8'h20; a < 8'h80; a++) rd_chk("R3 addr pattern", 8'(a));
    for (int b = 0; b < 8; b++) wr(8'h40 + 8'(b), 8'(1 << b));
    for (int b = 0; b < 8; b++) rd_chk("R3 walking one", 8'h40 + 8'(b));
  endtask

  task automatic t_bank1;
    for (int a = 8'hA0; a <= 8'hBF; a++) wr(8'(a), 8'(~a));
    for (int a = 8'hA0; a <= 8'hBF; a++) rd_chk("R4 bank1 ram", 8'(a));
    for (int a = 8'h20; a < 8'h40; a++) rd_chk("R4 bank0 untouched", 8'(a));
  endtask

  task automatic t_mirror;
    wr(8'hF0, 8'h11);
    rd_chk("R5 F0 to 70", 8'h70);
    wr(8'h7F, 8'h22);
    rd_chk("R5 7F to FF", 8'hFF);
    wr(8'hF8, 8'h33);
    rd_chk("R5 F8 to 78", 8'h78);
    rd_chk("R5 A0 distinct", 8'hA0);
    rd_chk("R5 50 distinct", 8'h50);
  endtask

  task automatic t_hole;
    for (int a = 8'hC0; a < 8'hF0; a += 7) begin
      @(negedge clk);
      put_addr(8'(a));
      wr_en = 1'b1;
      wr_data = 8'hEE;
      #1;
      chk("R6 hole no strobe", sfr_req | sfr_we, 0);
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      chk("R6 hole reads zero", rd_data, 0);
    end
    for (int a = 8'h20; a < 8'h80; a += 5) rd_chk("R6 ram intact", 8'(a));
    for (int a = 8'hA0; a <= 8'hBF; a += 3) rd_chk("R6 bank1 intact", 8'(a));
  endtask

  task automatic t_sfr;
    @(negedge clk);
    put_addr(8'h83);
    wr_en = 1'b1;
    wr_data = 8'h9C;
    #1;
    chk("R2 strobe", sfr_req, 1);
    chk("R2 bank", sfr_bank, 1);
    chk("R2 offset", sfr_ofs, 5'h03);
    chk("R9 write strobe", sfr_we, 1);
    chk("R9 write data", sfr_wdata, 8'h9C);
    chk("R2 read mux", rd_data, 8'h5A);
    @(negedge clk);
    wr_en = 1'b0;
    dir_ofs = 7'h1F;
    bank_sel = 1'b0;
    sfr_rdata = 8'hA7;
    #1;
    chk("R9 no write", sfr_we, 0);
    chk("R2 offset top", sfr_ofs, 5'h1F);
    chk("R2 bank0", sfr_bank, 0);
    chk("R2 read follows", rd_data, 8'hA7);
    rd_chk("R2 ram untouched 20", 8'h20);
    dir_ofs = 7'h20;
    #1;
    chk("R9 no strobe at 20h", sfr_req, 0);
  endtask

  task automatic t_pointer;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h25 : (i == 1) ? 8'hA5 : (i == 2) ? 8'hF3 : 8'h8A;
      @(negedge clk);
      use_ptr = 1'b1;
      ptr_addr = a;
      bank_sel = ~a[7];
      dir_ofs = 7'h33;
      #1;
      chk("R1 pointer read", rd_data, expect_rd(a));
      chk("R1 pointer strobe", sfr_req, (a[6:0] < 7'h20) ? 1'b1 : 1'b0);
    end
    @(negedge clk);
    use_ptr = 1'b1;
    ptr_addr = 8'hB2;
    bank_sel = 1'b0;
    wr_en = 1'b1;
    wr_data = 8'h6D;
    @(negedge clk);
    wr_en = 1'b0;
    use_ptr = 1'b0;
    model[8'hB2] = 8'h6D;
    rd_chk("R1 pointer write bank1", 8'hB2);
    rd_chk("R1 pointer write not bank0", 8'h32);
  endtask

  task automatic t_rsv;
    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      status_rsv = 2'(r);
      put_addr(8'h55);
      #1;
      chk("R7 read", rd_data, expect_rd(8'h55));
      put_addr(8'h85);
      #1;
      chk("R7 strobe bank", {sfr_req, sfr_bank}, 2'b11);
      put_addr(8'hD0);
      #1;
      chk("R7 hole", rd_data, 0);
    end
    wr(8'h66, 8'h4B);
    status_rsv = 2'b00;
    rd_chk("R7 write with rsv set", 8'h66);
  endtask

  task automatic t_rdw;
    wr(8'h3C, 8'h10);
    @(negedge clk);
    put_addr(8'h3C);
    wr_en = 1'b1;
    wr_data = 8'h99;
    #1;
    chk("R8 old before edge", rd_data, 8'h10);
    @(posedge clk);
    #1;
    chk("R8 new after edge", rd_data, 8'h99);
    @(negedge clk);
    wr_en = 1'b0;
    model[8'h3C] = 8'h99;
    put_addr(8'hBC);
    #1;
    chk("R8 address change immediate", rd_data, expect_rd(8'hBC));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_bank0_fill();
    t_bank1();
    t_mirror();
    t_hole();
    t_sfr();
    t_pointer();
    t_rsv();
    t_rdw();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule